// File: doc/BRIEF.md
# Low-Power DRAM Refresh Scheduler

This block sits in a memory controller and decides when one low-power DRAM channel needs a refresh, and which kind. A tick input advances an interval timer. The timer's period is a base interval scaled by a multiplier picked by a 5-bit rate code that follows the device temperature. Every expired interval adds one refresh to a signed debt. Granted refreshes pay that debt back. The command scheduler may grant early, which pulls refreshes in, or late, which postpones them. In both directions the allowance is a number of all-bank refreshes that depends on the rate code.

Per-bank refreshes are always counted against eight banks, whatever the bank organization. Each per-bank refresh is worth one eighth of an all-bank refresh. A coverage bitmap makes sure every bank is refreshed once in each group of eight. The request carries a bank address, or a bank-group bit plus bank address, formatted for the configured organization.

When partial-array refresh is on, the refresh slots that fall on masked segments are retired internally and never issued.

Top module: `refresh_sched`

## Requirements
- R1: The refresh interval in ticks is BASE_TICKS*E/8, where E (eighths of the base) comes from rate_code. The codes are 1:64, 2:48, 3:32, 4:26, 5:20, 6:16, 7:14, 8:10, 9:8, 10:6, 11:4, 12:2, 13:2, 14:1, 15:1, 31:1, and every other code gives 8. With BASE_TICKS=64 this means 512, 384, 256, 208, 160, 128, 112, 80, 64, 48, 32, 16, 16, 8, 8 and 8 ticks, and 64 ticks otherwise.
- R2: The allowance L, in all-bank refreshes, is 1 for codes 1 and 2, 2 for codes 3 and 4, 3 for code 5, 4 for code 6, 5 for code 7, 6 for code 8, and 8 for all other codes. Starting from reset with no ticks, exactly L all-bank grants are accepted before req_valid drops. After that, req_valid returns after exactly one interval of ticks.
- R3: In per-bank operation (use_per_bank=1), the requested bank is the lowest-numbered bank not yet refreshed in the current group of eight. After reset, successive grants therefore address banks 0 to 7, and then bank 0 again.
- R4: The bank_mode encoding is 0 for eight banks, 1 for sixteen banks, 2 for bank groups, and 3 behaves as 0. In modes 0, 1 and 3, req_ba equals the bank number and req_bg is 0. In mode 2, req_bg is {0, bank[2]} and req_ba is {0, bank[1:0]}.
- R5: An all-bank request (req_all_bank=1) is made only at a group boundary. If use_per_bank is cleared partway through a group, per-bank requests continue until the group is complete. Each completed slot (an all-bank grant, a finished group of eight, or a skip) advances the 3-bit segment index by one.
- R6: req_urgent is 1 when the debt has reached L intervals. It clears once a grant brings the debt back below that level. req_urgent implies req_valid.
- R7: When par_enable=1 and seg_mask bit [segment index] is 1 at a group boundary, no request is made. Any debt that is owed is retired one slot per cycle without a request. With par_enable=0, seg_mask has no effect.
- R8: rate_code 31 sets overtemp_err on the following cycle and uses the fastest interval from R1. Any other code clears overtemp_err on the following cycle.
- R9: After reset, req_valid=1, req_all_bank=1 (when use_per_bank=0), req_urgent=0, req_ba=0 and overtemp_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timer tick |
| rate_code | input | 5 | Temperature-dependent refresh rate code |
| bank_mode | input | 2 | Bank organization (0 eight-bank, 1 sixteen-bank, 2 bank-group) |
| use_per_bank | input | 1 | Select per-bank refreshes instead of all-bank |
| par_enable | input | 1 | Enable partial-array refresh skipping |
| seg_mask | input | 8 | Segments whose refreshes are skipped |
| grant | input | 1 | Scheduler accepts the current request |
| req_valid | output | 1 | A refresh may be issued now |
| req_all_bank | output | 1 | Request is all-bank (1) or per-bank (0) |
| req_urgent | output | 1 | Postponement limit reached |
| req_ba | output | 3 | Bank address of a per-bank request |
| req_bg | output | 2 | Bank-group address of a per-bank request |
| overtemp_err | output | 1 | Rate code signals over-temperature |

## Verification
The properties take for granted that grant is asserted only while req_valid is high. They also assume that tick is a single-cycle pulse. Under these assumptions the debt can never be driven below the largest pull-in floor, and every per-bank grant strictly raises the next bank number within a group. The stimulus raises grant only after it has sampled req_valid high, and it drives tick one cycle at a time. Rate-code changes are made only between measurements, while the debt is inside the allowance of both codes.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  localparam int NBANK = 8;
  localparam logic [4:0] CODE_HOT = 5'd31;

  typedef enum logic [1:0] {
    ORG_8B   = 2'd0,
    ORG_16B  = 2'd1,
    ORG_BG   = 2'd2,
    ORG_RSVD = 2'd3
  } org_t;

  // interval multiplier expressed in eighths of the base interval
  function automatic logic [6:0] rate_eighths(input logic [4:0] c);
    case (c)
      5'd1:    return 7'd64;
      5'd2:    return 7'd48;
      5'd3:    return 7'd32;
      5'd4:    return 7'd26;
      5'd5:    return 7'd20;
      5'd6:    return 7'd16;
      5'd7:    return 7'd14;
      5'd8:    return 7'd10;
      5'd9:    return 7'd8;
      5'd10:   return 7'd6;
      5'd11:   return 7'd4;
      5'd12:   return 7'd2;
      5'd13:   return 7'd2;
      5'd14:   return 7'd1;
      5'd15:   return 7'd1;
      CODE_HOT: return 7'd1;
      default: return 7'd8;
    endcase
  endfunction

  // postpone / pull-in allowance in all-bank refreshes
  function automatic logic [3:0] pull_limit(input logic [4:0] c);
    case (c)
      5'd1, 5'd2: return 4'd1;
      5'd3, 5'd4: return 4'd2;
      5'd5:       return 4'd3;
      5'd6:       return 4'd4;
      5'd7:       return 4'd5;
      5'd8:       return 4'd6;
      default:    return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/refi_timer.sv
module refi_timer
  import refsched_pkg::*;
#(
  parameter int BASE_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [4:0] rate_code,
  output logic       due
);
  localparam int PW = $clog2(BASE_TICKS) + 8;
  localparam int IW = PW - 3;

  logic [PW-1:0] prod;
  logic [IW-1:0] intv;
  logic [IW-1:0] cnt;
  logic [IW:0]   cnt_inc;

  always_comb begin
    prod = PW'(BASE_TICKS) * PW'(rate_eighths(rate_code));
    intv = prod[PW-1:3];
    if (intv == '0) intv = IW'(1);
  end

  assign cnt_inc = {1'b0, cnt} + (IW+1)'(1);
  assign due     = tick && (cnt_inc >= {1'b0, intv});

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (due)  cnt <= '0;
    else if (tick) cnt <= cnt_inc[IW-1:0];
  end
endmodule

// File: rtl/refresh_debt.sv
module refresh_debt
  import refsched_pkg::*;
#(
  parameter int DEBT_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     due,
  input  logic                     take_all,
  input  logic                     take_pb,
  input  logic                     skip,
  input  logic [4:0]               rate_code,
  output logic signed [DEBT_W-1:0] debt,
  output logic                     owed,
  output logic                     room_all,
  output logic                     room_pb,
  output logic                     urgent_lvl
);
  localparam logic signed [DEBT_W-1:0] ONE   = DEBT_W'(1);
  localparam logic signed [DEBT_W-1:0] EIGHT = DEBT_W'(8);
  localparam logic signed [DEBT_W-1:0] TOP   = DEBT_W'((1 << (DEBT_W-1)) - 9);

  logic signed [DEBT_W-1:0] lim8;
  logic signed [DEBT_W-1:0] debt_n;

  assign lim8 = $signed(DEBT_W'({pull_limit(rate_code), 3'b000}));

  assign owed       = debt > 0;
  assign room_all   = (debt - EIGHT) >= -lim8;
  assign room_pb    = (debt - ONE) >= -lim8;
  assign urgent_lvl = debt >= lim8;

  always_comb begin
    debt_n = debt;
    if (due && debt < TOP)  debt_n = debt_n + EIGHT;
    if (take_all || skip)   debt_n = debt_n - EIGHT;
    else if (take_pb)       debt_n = debt_n - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) debt <= '0;
    else     debt <= debt_n;
  end
endmodule

// File: rtl/bank_rotator.sv
module bank_rotator
  import refsched_pkg::*;
#(
  parameter int BANKS = NBANK,
  localparam int BW   = $clog2(BANKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_pb,
  input  logic          take_all,
  input  logic          skip,
  output logic [BW-1:0] next_bank,
  output logic          grp_empty,
  output logic [2:0]    seg
);
  logic [BANKS-1:0] cov;
  logic [BANKS-1:0] cov_set;
  logic [BANKS-1:0] pick;
  logic             found;

  always_comb begin
    next_bank = '0;
    found     = 1'b0;
    for (int i = 0; i < BANKS; i++) begin
      if (!found && !cov[i]) begin
        next_bank = BW'(i);
        found     = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_pick
    assign pick[g] = (next_bank == BW'(g));
  end

  assign cov_set   = cov | pick;
  assign grp_empty = (cov == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cov <= '0;
      seg <= '0;
    end else if (take_pb) begin
      if (&cov_set) begin
        cov <= '0;
        seg <= seg + 3'd1;
      end else begin
        cov <= cov_set;
      end
    end else if (take_all || skip) begin
      seg <= seg + 3'd1;
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int BASE_TICKS = 64,
  parameter int DEBT_W     = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [4:0] rate_code,
  input  logic [1:0] bank_mode,
  input  logic       use_per_bank,
  input  logic       par_enable,
  input  logic [7:0] seg_mask,
  input  logic       grant,
  output logic       req_valid,
  output logic       req_all_bank,
  output logic       req_urgent,
  output logic [2:0] req_ba,
  output logic [1:0] req_bg,
  output logic       overtemp_err
);
  logic                     due;
  logic signed [DEBT_W-1:0] debt;
  logic                     owed, room_all, room_pb, urgent_lvl;
  logic [2:0]               next_bank;
  logic [2:0]               seg;
  logic                     grp_empty;
  logic                     blocked, skip, want_all, take;
  logic                     take_all, take_pb;
  org_t                     org;

  refi_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .rate_code(rate_code), .due(due)
  );

  refresh_debt #(.DEBT_W(DEBT_W)) u_debt (
    .clk(clk), .rst(rst), .due(due), .take_all(take_all), .take_pb(take_pb),
    .skip(skip), .rate_code(rate_code), .debt(debt), .owed(owed),
    .room_all(room_all), .room_pb(room_pb), .urgent_lvl(urgent_lvl)
  );

  bank_rotator #(.BANKS(NBANK)) u_rot (
    .clk(clk), .rst(rst), .take_pb(take_pb), .take_all(take_all), .skip(skip),
    .next_bank(next_bank), .grp_empty(grp_empty), .seg(seg)
  );

  assign blocked  = par_enable && seg_mask[seg] && grp_empty;
  assign skip     = blocked && owed;
  assign want_all = !use_per_bank && grp_empty;

  assign req_all_bank = want_all;
  assign req_valid    = !blocked && (want_all ? room_all : room_pb);
  assign req_urgent   = !blocked && urgent_lvl;

  assign take     = grant && req_valid;
  assign take_all = take && want_all;
  assign take_pb  = take && !want_all;

  assign org = org_t'(bank_mode);

  always_comb begin
    case (org)
      ORG_BG: begin
        req_bg = {1'b0, next_bank[2]};
        req_ba = {1'b0, next_bank[1:0]};
      end
      default: begin
        req_bg = 2'b00;
        req_ba = next_bank;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) overtemp_err <= 1'b0;
    else     overtemp_err <= (rate_code == CODE_HOT);
  end
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int DEBT_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              grant,
  input logic              req_valid,
  input logic              req_all_bank,
  input logic              req_urgent,
  input logic [4:0]        rate_code,
  input logic              overtemp_err,
  input logic [2:0]        bank_id,
  input logic [2:0]        seg_idx,
  input logic [DEBT_W-1:0] debt_val
);
  localparam int FLOOR = -64;

  assert_urgent_valid_R6: assert property (@(posedge clk) disable iff (rst)
    req_urgent |-> req_valid);

  assert_hot_set_R8: assert property (@(posedge clk) disable iff (rst)
    (rate_code == 5'd31) |=> overtemp_err);

  assert_hot_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (rate_code != 5'd31) |=> !overtemp_err);

  assert_bank_order_R3: assert property (@(posedge clk) disable iff (rst)
    (grant && req_valid && !req_all_bank && bank_id != 3'd7) |=> (bank_id > $past(bank_id)));

  assert_seg_step_R5: assert property (@(posedge clk) disable iff (rst)
    (grant && req_valid && req_all_bank) |=> (seg_idx == $past(seg_idx) + 3'd1));

  assert_debt_floor_R2: assert property (@(posedge clk) disable iff (rst)
    int'($signed(debt_val)) >= FLOOR);
endmodule

bind refresh_sched refresh_sched_chk #(.DEBT_W(DEBT_W)) u_chk (
  .clk(clk), .rst(rst), .grant(grant), .req_valid(req_valid),
  .req_all_bank(req_all_bank), .req_urgent(req_urgent), .rate_code(rate_code),
  .overtemp_err(overtemp_err), .bank_id(next_bank), .seg_idx(seg),
  .debt_val(debt)
);

// File: tb/tb_refresh_sched.sv
`timescale 1ns/1ps
module tb_refresh_sched;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [4:0] rate_code = 5'd9;
  logic [1:0] bank_mode = 2'd0;
  logic       use_per_bank = 1'b0;
  logic       par_enable = 1'b0;
  logic [7:0] seg_mask = 8'h00;
  logic       grant = 1'b0;
  logic       req_valid, req_all_bank, req_urgent, overtemp_err;
  logic [2:0] req_ba;
  logic [1:0] req_bg;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  refresh_sched dut (
    .clk(clk), .rst(rst), .tick(tick), .rate_code(rate_code),
    .bank_mode(bank_mode), .use_per_bank(use_per_bank),
    .par_enable(par_enable), .seg_mask(seg_mask), .grant(grant),
    .req_valid(req_valid), .req_all_bank(req_all_bank),
    .req_urgent(req_urgent), .req_ba(req_ba), .req_bg(req_bg),
    .overtemp_err(overtemp_err)
  );

  // {code[20:16], interval ticks[15:4], allowance[3:0]}
  localparam logic [20:0] VEC [17] = '{
    {5'd1,  12'd512, 4'd1}, {5'd2,  12'd384, 4'd1}, {5'd3,  12'd256, 4'd2},
    {5'd4,  12'd208, 4'd2}, {5'd5,  12'd160, 4'd3}, {5'd6,  12'd128, 4'd4},
    {5'd7,  12'd112, 4'd5}, {5'd8,  12'd80,  4'd6}, {5'd9,  12'd64,  4'd8},
    {5'd10, 12'd48,  4'd8}, {5'd11, 12'd32,  4'd8}, {5'd12, 12'd16,  4'd8},
    {5'd13, 12'd16,  4'd8}, {5'd14, 12'd8,   4'd8}, {5'd15, 12'd8,   4'd8},
    {5'd31, 12'd8,   4'd8}, {5'd0,  12'd64,  4'd8}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick = 1'b0;
    grant = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(posedge clk);
    #1 tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_grant();
    grant = 1'b1;
    @(posedge clk);
    #1 grant = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    do_reset();

    // R9 reset state
    chk("R9 req_valid", int'(req_valid), 1);
    chk("R9 req_all_bank", int'(req_all_bank), 1);
    chk("R9 req_urgent", int'(req_urgent), 0);
    chk("R9 req_ba", int'(req_ba), 0);
    chk("R9 overtemp_err", int'(overtemp_err), 0);

    // R1 / R2 table walk
    for (int i = 0; i < 17; i++) begin
      rate_code = VEC[i][20:16];
      do_reset();
      n = 0;
      while (req_valid && n < 20) begin
        do_grant();
        n++;
      end
      chk($sformatf("R2 pull-in count code %0d", VEC[i][20:16]), n, int'(VEC[i][3:0]));
      n = 0;
      do begin
        pulse_tick();
        n++;
      end while (!req_valid && n < 1000);
      chk($sformatf("R1 interval code %0d", VEC[i][20:16]), n, int'(VEC[i][15:4]));
    end

    // R6 urgency: code 15, interval 8, allowance 8
    rate_code = 5'd15;
    do_reset();
    for (int k = 0; k < 63; k++) pulse_tick();
    chk("R6 urgent before limit", int'(req_urgent), 0);
    pulse_tick();
    chk("R6 urgent at limit", int'(req_urgent), 1);
    chk("R6 valid with urgent", int'(req_valid), 1);
    do_grant();
    chk("R6 urgent cleared", int'(req_urgent), 0);

    // R3 / R4 per-bank rotation, eight-bank mode
    rate_code = 5'd9;
    use_per_bank = 1'b1;
    bank_mode = 2'd0;
    do_reset();
    for (int b = 0; b < 8; b++) begin
      chk($sformatf("R3 bank order step %0d", b), int'(req_ba), b);
      chk("R5 per-bank kind", int'(req_all_bank), 0);
      do_grant();
    end
    chk("R3 wrap to bank 0", int'(req_ba), 0);

    // R4 bank-group mapping
    bank_mode = 2'd2;
    do_reset();
    for (int b = 0; b < 8; b++) begin
      chk($sformatf("R4 bg step %0d", b), int'(req_bg), b >> 2);
      chk($sformatf("R4 ba step %0d", b), int'(req_ba), b & 3);
      do_grant();
    end

    // R4 sixteen-bank mode maps like eight-bank
    bank_mode = 2'd1;
    do_reset();
    for (int b = 0; b < 5; b++) do_grant();
    chk("R4 16B ba", int'(req_ba), 5);
    chk("R4 16B bg", int'(req_bg), 0);

    // R5 switch to all-bank mid-group
    bank_mode = 2'd0;
    do_reset();
    for (int b = 0; b < 3; b++) do_grant();
    use_per_bank = 1'b0;
    #1;
    chk("R5 group continues", int'(req_all_bank), 0);
    chk("R5 group bank", int'(req_ba), 3);
    for (int b = 0; b < 5; b++) do_grant();
    chk("R5 all-bank at boundary", int'(req_all_bank), 1);

    // R8 over-temperature flag
    do_reset();
    rate_code = 5'd31;
    idle(1);
    chk("R8 err set", int'(overtemp_err), 1);
    rate_code = 5'd9;
    idle(1);
    chk("R8 err cleared", int'(overtemp_err), 0);

    // R7 partial-array skipping
    rate_code = 5'd15;
    par_enable = 1'b1;
    seg_mask = 8'h01;
    do_reset();
    #1;
    chk("R7 masked segment blocked", int'(req_valid), 0);
    for (int k = 0; k < 8; k++) pulse_tick();
    idle(1);
    chk("R7 skip advances segment", int'(req_valid), 1);
    seg_mask = 8'hFF;
    #1;
    chk("R7 all masked blocked", int'(req_valid), 0);
    for (int k = 0; k < 80; k++) pulse_tick();
    idle(1);
    chk("R7 skipped debt no urgency", int'(req_urgent), 0);
    chk("R7 skipped debt no request", int'(req_valid), 0);
    par_enable = 1'b0;
    #1;
    chk("R7 mask ignored when disabled", int'(req_valid), 1);
    chk("R7 debt retired", int'(req_urgent), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule